// File: doc/BRIEF.md
# Hardware Cursor Overlay

This block draws a small two-bit-per-pixel cursor image over a stream of display pixels. A host loads a 32 by 32 cursor pattern into an internal byte-wide pattern memory. It also supplies a set of static settings: where the hot spot sits inside the image, where the hot spot should appear on screen, a mode bit, and three replacement colours.

For every incoming pixel the block compares the pixel's raster coordinates with the cursor rectangle. Pixels inside the rectangle are looked up in the pattern memory. The two-bit code then either replaces the pixel with a colour, lets it through, or replaces it with its bitwise complement or an auxiliary colour, depending on the mode bit. Pixels outside the rectangle, and every pixel while the cursor is switched off, pass through unchanged.

The pattern memory is read synchronously, so each pixel takes two clock cycles from input to registered output. The stream may have gaps.

Top module: `cursor_overlay`

## Requirements
- R1: Pattern byte address a = row*8 + col/4 holds four pixels of one row. Column col sits in bits [2*(col%4)+1 : 2*(col%4)], so the lowest column of the group is in bits 1:0 and the highest in bits 7:6.
- R2: A covered pixel whose code is 2'b00 is output as `col_second`.
- R3: A covered pixel whose code is 2'b01 is output as `col_first`.
- R4: A covered pixel whose code is 2'b10 is output unchanged.
- R5: A covered pixel whose code is 2'b11 is output as the bitwise complement of the input pixel when `cur_mode` is 0.
- R6: A covered pixel whose code is 2'b11 is output as `col_aux` when `cur_mode` is 1.
- R7: The image's top-left screen corner is the hot-spot position minus the hot-spot offset on each axis, floored at 0, so the cursor never crosses the left or top border.
- R8: A pixel is covered only when 0 <= x - corner_x < 32 and 0 <= y - corner_y < 32. Pixels outside pass through unchanged, so a cursor near the right or bottom border is clipped.
- R9: While `cur_en` is 0, every pixel passes through unchanged.
- R10: `out_valid` repeats `in_valid` exactly two clock cycles later, and `out_pix` belongs to that same pixel.
- R11: While `rst_n` is low, `out_valid` and `out_pix` are 0.
- R12: When `cur_en` is 1, the pixel at exactly the hot-spot screen position is always covered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pat_we | input | 1 | Pattern memory write strobe |
| pat_addr | input | 8 | Pattern memory byte address |
| pat_wdata | input | 8 | Pattern memory write byte |
| cur_en | input | 1 | Cursor enable |
| cur_mode | input | 1 | Meaning of code 2'b11: 0 complement, 1 auxiliary colour |
| hot_off_x | input | 5 | Hot-spot column inside the image |
| hot_off_y | input | 5 | Hot-spot row inside the image |
| hot_pos_x | input | 12 | Hot-spot screen x |
| hot_pos_y | input | 12 | Hot-spot screen y |
| col_first | input | 24 | First cursor colour |
| col_second | input | 24 | Second cursor colour |
| col_aux | input | 24 | Auxiliary cursor colour |
| in_valid | input | 1 | Input pixel qualifier |
| in_x | input | 12 | Raster x of input pixel |
| in_y | input | 12 | Raster y of input pixel |
| in_pix | input | 24 | Input pixel value |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 24 | Output pixel value |

## Verification
The assertions assume that the settings (mode, enable, colours, positions) stay constant while a pixel is inside the two-stage pipeline. They also assume that pattern writes never coincide with valid pixels whose lookup they could affect. The bench honours both assumptions: every settings change or pattern load is preceded by two idle cycles and followed only by new pixels. Within a scan, the stimulus inserts idle gaps at irregular points. The scans cover a normal placement, a placement clamped at the top-left corner, a placement clipped at the right and bottom borders of a 640x480 raster, both mode values, and the disabled state.

// File: rtl/cur_pkg.sv
// Shared definitions for the cursor overlay: pattern code width and meanings.
// Assumes two bits per cursor pixel.
package cur_pkg;
    localparam int CODE_W = 2;

    typedef enum logic [CODE_W-1:0] {
        CODE_SECOND  = 2'b00,
        CODE_FIRST   = 2'b01,
        CODE_CLEAR   = 2'b10,
        CODE_SPECIAL = 2'b11
    } cur_code_e;
endpackage

// File: rtl/cur_pattern_ram.sv
// Cursor pattern storage: one byte-wide write port and one synchronous read port.
// A read of an address being written in the same cycle returns the old byte.
module cur_pattern_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the host byte.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered lookup for the pixel path.
    always_ff @(posedge clk) begin
        rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/cur_window.sv
// Cursor placement: derives the clamped top-left corner, tests whether the
// current raster position lies inside the cursor square, and forms the
// pattern byte address and the pixel index inside that byte.
// Assumes the offsets are narrower than the screen coordinates.
module cur_window #(
    parameter int XW      = 12,
    parameter int YW      = 12,
    parameter int CUR_DIM = 32,
    parameter int SUB_W   = 2,
    localparam int CL     = $clog2(CUR_DIM),
    localparam int AW     = 2*CL - SUB_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             in_valid,
    input  logic [CL-1:0]    off_x,
    input  logic [CL-1:0]    off_y,
    input  logic [XW-1:0]    pos_x,
    input  logic [YW-1:0]    pos_y,
    input  logic [XW-1:0]    in_x,
    input  logic [YW-1:0]    in_y,
    output logic             hit,
    output logic [AW-1:0]    addr,
    output logic [SUB_W-1:0] sub
);
    logic [XW-1:0] org_x, dx;
    logic [YW-1:0] org_y, dy;
    logic          in_x_rng, in_y_rng;

    // Corner = hot-spot position minus offset, floored at zero.
    always_comb begin
        org_x = (pos_x >= XW'(off_x)) ? pos_x - XW'(off_x) : '0;
        org_y = (pos_y >= YW'(off_y)) ? pos_y - YW'(off_y) : '0;
    end

    // Coverage test and pattern addressing.
    always_comb begin
        dx       = in_x - org_x;
        dy       = in_y - org_y;
        in_x_rng = (in_x >= org_x) && (dx < XW'(CUR_DIM));
        in_y_rng = (in_y >= org_y) && (dy < YW'(CUR_DIM));
        hit      = en && in_x_rng && in_y_rng;
        addr     = {dy[CL-1:0], dx[CL-1:SUB_W]};
        sub      = dx[SUB_W-1:0];
    end

    // R12
    hotspot_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && en && in_x == pos_x && in_y == pos_y) |-> hit);
endmodule

// File: rtl/cur_color_mux.sv
// Output selection for one pixel from its pattern code, coverage flag and mode.
// Assumes the colour inputs are stable for the cycle the pixel is in this stage.
module cur_color_mux
    import cur_pkg::*;
#(
    parameter int PIX_W = 24
) (
    input  logic             hit,
    input  logic             mode,
    input  cur_code_e        code,
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] col_first,
    input  logic [PIX_W-1:0] col_second,
    input  logic [PIX_W-1:0] col_aux,
    output logic [PIX_W-1:0] result
);
    // Substitute, pass or complement according to the code.
    always_comb begin
        result = pix;
        if (hit) begin
            unique case (code)
                CODE_SECOND:  result = col_second;
                CODE_FIRST:   result = col_first;
                CODE_CLEAR:   result = pix;
                CODE_SPECIAL: result = mode ? col_aux : ~pix;
                default:      result = pix;
            endcase
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
// Cursor overlay top: stage 0 tests coverage and addresses the pattern
// memory, stage 1 picks the two-bit code out of the fetched byte and
// selects the output pixel, which is registered. Latency is two cycles.
// Assumes settings are held while pixels are in flight.
module cursor_overlay
    import cur_pkg::*;
#(
    parameter int PIX_W   = 24,
    parameter int XW      = 12,
    parameter int YW      = 12,
    parameter int CUR_DIM = 32,
    parameter int BYTE_W  = 8,
    localparam int CL           = $clog2(CUR_DIM),
    localparam int PIX_PER_BYTE = BYTE_W / CODE_W,
    localparam int SUB_W        = $clog2(PIX_PER_BYTE),
    localparam int BYTES_PER_ROW = CUR_DIM / PIX_PER_BYTE,
    localparam int RAM_DEPTH    = CUR_DIM * BYTES_PER_ROW,
    localparam int AW           = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pat_we,
    input  logic [AW-1:0]     pat_addr,
    input  logic [BYTE_W-1:0] pat_wdata,
    input  logic              cur_en,
    input  logic              cur_mode,
    input  logic [CL-1:0]     hot_off_x,
    input  logic [CL-1:0]     hot_off_y,
    input  logic [XW-1:0]     hot_pos_x,
    input  logic [YW-1:0]     hot_pos_y,
    input  logic [PIX_W-1:0]  col_first,
    input  logic [PIX_W-1:0]  col_second,
    input  logic [PIX_W-1:0]  col_aux,
    input  logic              in_valid,
    input  logic [XW-1:0]     in_x,
    input  logic [YW-1:0]     in_y,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_pix
);
    logic              s0_hit;
    logic [AW-1:0]     s0_addr;
    logic [SUB_W-1:0]  s0_sub;
    logic              s1_valid, s1_hit;
    logic [SUB_W-1:0]  s1_sub;
    logic [PIX_W-1:0]  s1_pix;
    logic [BYTE_W-1:0] ram_rdata;
    cur_code_e         s1_code;
    logic [PIX_W-1:0]  mux_pix;
    logic [1:0]        age;

    cur_window #(
        .XW(XW), .YW(YW), .CUR_DIM(CUR_DIM), .SUB_W(SUB_W)
    ) u_window (
        .clk(clk), .rst_n(rst_n), .en(cur_en), .in_valid(in_valid),
        .off_x(hot_off_x), .off_y(hot_off_y),
        .pos_x(hot_pos_x), .pos_y(hot_pos_y),
        .in_x(in_x), .in_y(in_y),
        .hit(s0_hit), .addr(s0_addr), .sub(s0_sub)
    );

    cur_pattern_ram #(.DATA_W(BYTE_W), .DEPTH(RAM_DEPTH)) u_ram (
        .clk(clk), .wr_en(pat_we), .wr_addr(pat_addr), .wr_data(pat_wdata),
        .rd_addr(s0_addr), .rd_data(ram_rdata)
    );

    // Stage 1: carry pixel and coverage alongside the memory read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_sub   <= '0;
            s1_pix   <= '0;
        end else begin
            s1_valid <= in_valid;
            s1_hit   <= s0_hit;
            s1_sub   <= s0_sub;
            s1_pix   <= in_pix;
        end
    end

    // Pick this pixel's code out of the fetched byte (low column in low bits).
    always_comb begin
        s1_code = cur_code_e'(ram_rdata[s1_sub*CODE_W +: CODE_W]);
    end

    cur_color_mux #(.PIX_W(PIX_W)) u_mux (
        .hit(s1_hit), .mode(cur_mode), .code(s1_code), .pix(s1_pix),
        .col_first(col_first), .col_second(col_second), .col_aux(col_aux),
        .result(mux_pix)
    );

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_valid;
            out_pix   <= mux_pix;
        end
    end

    // Cycles since reset, saturating, to bound look-back in checks.
    always_ff @(posedge clk) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    // R10
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R9
    disabled_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age >= 2'd2 && out_valid && !$past(cur_en, 2)) |-> (out_pix == $past(in_pix, 2)));

    // R4
    clear_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_hit && s1_code == CODE_CLEAR) |=> (out_pix == $past(s1_pix)));

    // R3
    first_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && s1_hit && s1_code == CODE_FIRST) |=> (out_pix == $past(col_first)));
endmodule

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        pat_we;
    logic [7:0]  pat_addr, pat_wdata;
    logic        cur_en, cur_mode;
    logic [4:0]  hot_off_x, hot_off_y;
    logic [11:0] hot_pos_x, hot_pos_y;
    logic [23:0] col_first, col_second, col_aux;
    logic        in_valid;
    logic [11:0] in_x, in_y;
    logic [23:0] in_pix;
    logic        out_valid;
    logic [23:0] out_pix;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [7:0] model_mem [256];
    bit          q_valid [$];
    logic [23:0] q_pix   [$];
    string       q_tag   [$];

    always #10 clk = ~clk;

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .cur_en(cur_en), .cur_mode(cur_mode),
        .hot_off_x(hot_off_x), .hot_off_y(hot_off_y),
        .hot_pos_x(hot_pos_x), .hot_pos_y(hot_pos_y),
        .col_first(col_first), .col_second(col_second), .col_aux(col_aux),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pix(in_pix),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    // Behavioural expectation for one pixel under the current settings.
    task automatic model(input int x, input int y, input logic [23:0] p,
                         output logic [23:0] r, output string tag);
        int ox, oy, c, rw, code;
        if (!cur_en) begin r = p; tag = "R9"; return; end
        ox = (hot_pos_x >= hot_off_x) ? hot_pos_x - hot_off_x : 0;
        oy = (hot_pos_y >= hot_off_y) ? hot_pos_y - hot_off_y : 0;
        if (x < ox || x >= ox + 32 || y < oy || y >= oy + 32) begin
            r = p; tag = "R8"; return;
        end
        c = x - ox; rw = y - oy;
        code = (model_mem[rw*8 + c/4] >> (2*(c%4))) & 3;
        case (code)
            0: begin r = col_second; tag = "R2"; end
            1: begin r = col_first;  tag = "R3"; end
            2: begin r = p;          tag = "R4"; end
            default: begin
                if (cur_mode) begin r = col_aux; tag = "R6"; end
                else          begin r = ~p;      tag = "R5"; end
            end
        endcase
        if (hot_off_x > hot_pos_x || hot_off_y > hot_pos_y) tag = {tag, "/R7"};
        tag = {tag, "/R1"};
    endtask

    // One cycle: compare the output due now, then drive and record the next input.
    task automatic tick(input bit v, input int x, input int y, input logic [23:0] p);
        logic [23:0] e; string t;
        @(negedge clk);
        if (q_valid.size() == 2) begin
            bit ev; logic [23:0] ep; string et;
            ev = q_valid.pop_front(); ep = q_pix.pop_front(); et = q_tag.pop_front();
            checks++;
            if (out_valid !== ev) begin
                fails++;
                $display("FAIL R10 out_valid=%0b expected %0b", out_valid, ev);
            end else if (ev && out_pix !== ep) begin
                fails++;
                $display("FAIL %s out_pix=%h expected %h", et, out_pix, ep);
            end
        end
        in_valid = v; in_x = 12'(x); in_y = 12'(y); in_pix = p;
        model(x, y, p, e, t);
        q_valid.push_back(v); q_pix.push_back(e); q_tag.push_back(t);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, 24'h0);
    endtask

    task automatic load_pattern(input bit fixed);
        idle(2);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b;
            b = fixed ? 8'hE4 : 8'((a*73 + 29) ^ (a >> 3));
            pat_we = 1'b1; pat_addr = 8'(a); pat_wdata = b;
            model_mem[a] = b;
            tick(0, 0, 0, 24'h0);
        end
        pat_we = 1'b0;
        idle(2);
    endtask

    task automatic set_cfg(input bit en, input bit md, input int px, input int py,
                           input int offx, input int offy);
        idle(2);
        cur_en = en; cur_mode = md;
        hot_pos_x = 12'(px); hot_pos_y = 12'(py);
        hot_off_x = 5'(offx); hot_off_y = 5'(offy);
    endtask

    task automatic scan(input int x0, input int x1, input int y0, input int y1);
        for (int y = y0; y <= y1; y++)
            for (int x = x0; x <= x1; x++) begin
                tick(1, x, y, {x[7:0], y[7:0], 8'(x ^ (y * 3))});
                if ($urandom_range(0, 6) == 0) tick(0, x, y, 24'h0);
            end
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pat_we = 1'b0; pat_addr = '0; pat_wdata = '0;
        cur_en = 1'b0; cur_mode = 1'b0;
        hot_off_x = '0; hot_off_y = '0; hot_pos_x = '0; hot_pos_y = '0;
        col_first = 24'hFF2010; col_second = 24'h10E0F0; col_aux = 24'h55AA33;
        in_valid = 1'b0; in_x = '0; in_y = '0; in_pix = 24'h123456;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: reset state
        checks++;
        if (out_valid !== 1'b0 || out_pix !== 24'h0) begin
            fails++;
            $display("FAIL R11 out_valid=%0b out_pix=%h expected 0 000000", out_valid, out_pix);
        end
        rst_n = 1'b1;
        q_valid.push_back(0); q_pix.push_back(24'h0); q_tag.push_back("R11");

        load_pattern(0);
        // R2 R3 R4 R5: normal placement, complement mode
        set_cfg(1, 0, 20, 16, 4, 6);
        scan(10, 52, 6, 44);
        // R6: auxiliary mode
        set_cfg(1, 1, 20, 16, 4, 6);
        scan(14, 50, 8, 43);
        // R7: offset larger than position clamps to top-left
        set_cfg(1, 0, 5, 3, 20, 25);
        scan(0, 36, 0, 35);
        // R7: position equal to offset lands exactly at the origin
        set_cfg(1, 1, 31, 31, 31, 31);
        scan(0, 34, 0, 33);
        // R8: clipped at right and bottom of a 640x480 raster
        set_cfg(1, 0, 630, 470, 2, 2);
        scan(620, 639, 460, 479);
        // R9: disabled
        set_cfg(0, 0, 20, 16, 4, 6);
        scan(14, 40, 10, 30);
        // R1: fixed byte 8'hE4 gives codes 00,01,10,11 for columns 0..3 of each group
        load_pattern(1);
        set_cfg(1, 0, 100, 50, 0, 0);
        scan(98, 133, 49, 83);
        idle(4);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule